// File: doc/BRIEF.md
# Exception Frame Builder and Return Sequencer

This block is the part of a small 32-bit big-endian processor core that handles exception entry and exception return. When a request arrives it computes a two-longword frame, writes it below the supervisor stack pointer, reads the handler address from the vector table, and hands the core a new program counter, status register and stack pointer in a single commit cycle. The frame also records the two low bits of the stack pointer as it stood before entry, so a misaligned stack survives the round trip.

The return operation reads the frame back from the current stack pointer, rebuilds the original stack pointer with its low bits, and restores the saved status word. Both operations use one single-beat 32-bit memory port with a ready handshake. Stack-pointer banking and instruction decode belong to the surrounding core.

Top module: `exc_frame_seq`

## Requirements
- R1: The pushed format longword holds bits 31:30 = 2'b01, bits 29:28 = the entry stack pointer's bits 1:0, bits 27:26 = 0, bits 25:16 = vector index times 4, and bits 15:0 = the full entry status word.
- R2: Entry writes use an aligned base B = stack pointer with bits 1:0 cleared. The return address is written at B-4 first, then the format longword at B-8. The committed stack pointer is B-8. Every write address is a multiple of 4.
- R3: The saved return address is the current PC plus 2 for vector indices 32 through 47 (software traps). It is the current PC for every other index.
- R4: On entry the committed status word equals the entry word with bit 13 (supervisor) set. For a hardware request, bits 10:8 (interrupt mask) are also replaced by the pending level and bit 12 (master state) is cleared.
- R5: After the two writes, the entry reads address VBR + 4 x vector index, and the committed PC is the value read there.
- R6: A return reads the format longword at SP and then the PC at SP+4. It commits the PC read, the status word from format bits 15:0, and the stack pointer (SP OR format bits 29:28) + 8.
- R7: A hardware request is accepted only when status bits 10:8 are strictly less than the pending level. Otherwise it is ignored: busy stays low, no memory access is made and no done pulse appears.
- R8: Only one memory access is outstanding at a time. While ready is low, the request, the address and the direction are held. The memory request is never high without busy.
- R9: Done is high for exactly one cycle per operation, with busy low. The new PC, status and stack pointer outputs change only in that cycle, all three together.
- R10: After reset, busy, done and the memory request are low, and the new PC, status and stack pointer outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Exception entry request (taken when idle) |
| ret_valid | input | 1 | Return request (taken when idle and no entry request) |
| exc_vec | input | 8 | Vector index |
| exc_hw | input | 1 | 1 = hardware interrupt, 0 = software exception |
| exc_level | input | 3 | Pending interrupt level for hardware requests |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 16 | Current status word |
| cur_sp | input | 32 | Current supervisor stack pointer |
| cur_vbr | input | 32 | Vector table base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle commit strobe |
| new_pc | output | 32 | Committed program counter |
| new_sr | output | 16 | Committed status word |
| new_sp | output | 32 | Committed stack pointer |

## Verification
Each random entry is followed at once by a return from the committed stack pointer. The round trip must give back the original PC (or PC+2), the original status word and the original, possibly misaligned, stack pointer. This separates a frame that merely looks plausible from one whose tag bits, vector field and alignment bits are actually used. Directed cases place the vector index at the trap range edges (31, 32, 47, 48), cover all four stack-pointer low-bit values, and set the master bit with hardware requests. Further cases send hardware requests whose level equals or falls below the mask, which must leave the port silent. Random ready delays show that addresses hold during wait states.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;

    localparam int XLEN   = 32;
    localparam int SRW    = 16;
    localparam int VECW   = 8;
    localparam int LVLW   = 3;

    localparam int SR_SUPER_BIT  = 13;
    localparam int SR_MASTER_BIT = 12;
    localparam int SR_MASK_LO    = 8;

    localparam logic [1:0] FMT_TAG = 2'b01;
    localparam int FRAME_BYTES = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_RET,
        ST_PUSH_FMT,
        ST_FETCH_VEC,
        ST_POP_FMT,
        ST_POP_PC
    } seq_state_e;

    typedef struct packed {
        logic [XLEN-1:0] ret_addr;
        logic [XLEN-1:0] fmt_word;
        logic [XLEN-1:0] sp_base;
        logic [XLEN-1:0] vec_addr;
        logic [SRW-1:0]  sr_next;
    } entry_plan_t;

    function automatic logic [XLEN-1:0] build_format(
        input logic [VECW-1:0] vec,
        input logic [1:0]      sp_lo,
        input logic [SRW-1:0]  sr
    );
        return {FMT_TAG, sp_lo, 2'b00, vec, 2'b00, sr};
    endfunction

endpackage

// File: rtl/exc_frame_calc.sv
module exc_frame_calc
    import exc_frame_pkg::*;
#(
    parameter int TRAP_BASE = 32,
    parameter int TRAP_NUM  = 16
) (
    input  logic [VECW-1:0] vec,
    input  logic            hw,
    input  logic [LVLW-1:0] level,
    input  logic [XLEN-1:0] pc,
    input  logic [SRW-1:0]  sr,
    input  logic [XLEN-1:0] sp,
    input  logic [XLEN-1:0] vbr,
    output logic            accept,
    output entry_plan_t     plan
);
    localparam int TRAP_END = TRAP_BASE + TRAP_NUM;

    logic            is_trap;
    logic [SRW-1:0]  sr_mod;

    always_comb begin
        is_trap = (int'(vec) >= TRAP_BASE) && (int'(vec) < TRAP_END);
        // R7: hardware request needs mask strictly below level
        accept  = !hw || (sr[SR_MASK_LO +: LVLW] < level);

        // R4: supervisor on, hardware also loads mask and clears master
        sr_mod = sr;
        sr_mod[SR_SUPER_BIT] = 1'b1;
        if (hw) begin
            sr_mod[SR_MASK_LO +: LVLW] = level;
            sr_mod[SR_MASTER_BIT]      = 1'b0;
        end

        plan.ret_addr = is_trap ? pc + XLEN'(2) : pc;            // R3
        plan.fmt_word = build_format(vec, sp[1:0], sr);          // R1
        plan.sp_base  = {sp[XLEN-1:2], 2'b00};                   // R2
        plan.vec_addr = vbr + {{(XLEN-VECW-2){1'b0}}, vec, 2'b00}; // R5
        plan.sr_next  = sr_mod;
    end

endmodule

// File: rtl/exc_frame_fsm.sv
module exc_frame_fsm
    import exc_frame_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start_exc,
    input  logic            start_ret,
    input  entry_plan_t     plan,
    input  logic [XLEN-1:0] cur_sp,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_ready,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] new_pc,
    output logic [SRW-1:0]  new_sr,
    output logic [XLEN-1:0] new_sp
);
    seq_state_e      state;
    entry_plan_t     plan_q;
    logic [XLEN-1:0] ret_sp;
    logic [1:0]      pop_lo;
    logic [SRW-1:0]  pop_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            plan_q <= '0;
            ret_sp <= '0;
            pop_lo <= '0;
            pop_sr <= '0;
            done   <= 1'b0;
            new_pc <= '0;
            new_sr <= '0;
            new_sp <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_exc) begin
                        plan_q <= plan;
                        state  <= ST_PUSH_RET;
                    end else if (start_ret) begin
                        ret_sp <= cur_sp;
                        state  <= ST_POP_FMT;
                    end
                end
                ST_PUSH_RET:  if (mem_ready) state <= ST_PUSH_FMT;
                ST_PUSH_FMT:  if (mem_ready) state <= ST_FETCH_VEC;
                ST_FETCH_VEC: if (mem_ready) begin
                    new_pc <= mem_rdata;                          // R5
                    new_sr <= plan_q.sr_next;
                    new_sp <= plan_q.sp_base - XLEN'(FRAME_BYTES);
                    done   <= 1'b1;                               // R9
                    state  <= ST_IDLE;
                end
                ST_POP_FMT: if (mem_ready) begin
                    pop_lo <= mem_rdata[29:28];
                    pop_sr <= mem_rdata[SRW-1:0];
                    state  <= ST_POP_PC;
                end
                ST_POP_PC: if (mem_ready) begin
                    new_pc <= mem_rdata;                          // R6
                    new_sr <= pop_sr;
                    new_sp <= (ret_sp | {{(XLEN-2){1'b0}}, pop_lo})
                              + XLEN'(FRAME_BYTES);
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        mem_req   = busy;                                          // R8
        mem_we    = (state == ST_PUSH_RET) || (state == ST_PUSH_FMT);
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_PUSH_RET: begin
                mem_addr  = plan_q.sp_base - XLEN'(4);
                mem_wdata = plan_q.ret_addr;
            end
            ST_PUSH_FMT: begin
                mem_addr  = plan_q.sp_base - XLEN'(8);
                mem_wdata = plan_q.fmt_word;
            end
            ST_FETCH_VEC: mem_addr = plan_q.vec_addr;
            ST_POP_FMT:   mem_addr = ret_sp;
            ST_POP_PC:    mem_addr = ret_sp + XLEN'(4);
            default:      mem_addr = '0;
        endcase
    end

endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
    import exc_frame_pkg::*;
#(
    parameter int TRAP_BASE = 32,
    parameter int TRAP_NUM  = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            exc_valid,
    input  logic            ret_valid,
    input  logic [VECW-1:0] exc_vec,
    input  logic            exc_hw,
    input  logic [LVLW-1:0] exc_level,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [SRW-1:0]  cur_sr,
    input  logic [XLEN-1:0] cur_sp,
    input  logic [XLEN-1:0] cur_vbr,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_ready,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] new_pc,
    output logic [SRW-1:0]  new_sr,
    output logic [XLEN-1:0] new_sp
);
    entry_plan_t plan;
    logic        accept;
    logic        start_exc;

    exc_frame_calc #(
        .TRAP_BASE (TRAP_BASE),
        .TRAP_NUM  (TRAP_NUM)
    ) u_calc (
        .vec    (exc_vec),
        .hw     (exc_hw),
        .level  (exc_level),
        .pc     (cur_pc),
        .sr     (cur_sr),
        .sp     (cur_sp),
        .vbr    (cur_vbr),
        .accept (accept),
        .plan   (plan)
    );

    assign start_exc = exc_valid && accept;

    exc_frame_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_exc (start_exc),
        .start_ret (ret_valid && !exc_valid),
        .plan      (plan),
        .cur_sp    (cur_sp),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .busy      (busy),
        .done      (done),
        .new_pc    (new_pc),
        .new_sr    (new_sr),
        .new_sp    (new_sp)
    );

endmodule

// File: rtl/exc_frame_chk.sv
module exc_frame_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ready,
    input logic [31:0] mem_addr,
    input logic        busy,
    input logic        done,
    input logic [31:0] new_pc,
    input logic [15:0] new_sr,
    input logic [31:0] new_sp
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R8

    AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy); // R8

    AST_WRITE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr[1:0] == 2'b00)); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(new_pc) && $stable(new_sr) && $stable(new_sp))); // R9
endmodule

bind exc_frame_seq exc_frame_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .done      (done),
    .new_pc    (new_pc),
    .new_sr    (new_sr),
    .new_sp    (new_sp)
);

// File: tb/exc_frame_seq_bench.sv
`timescale 1ns/1ps
module exc_frame_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_valid = 1'b0, ret_valid = 1'b0, exc_hw = 1'b0;
    logic [7:0]  exc_vec = '0;
    logic [2:0]  exc_level = '0;
    logic [31:0] cur_pc = '0, cur_sp = '0, cur_vbr = '0;
    logic [15:0] cur_sr = '0;
    logic        mem_req, mem_we, mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        busy, done;
    logic [31:0] new_pc, new_sp;
    logic [15:0] new_sr;

    int errors = 0, checks = 0, cycles = 0, beats = 0, wait_cnt = 0;
    logic [31:0] mem [logic [31:0]];

    always #2 clk = ~clk;

    exc_frame_seq u_exc_frame_seq (.*);

    function automatic logic [31:0] dflt(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    // memory model: random 0..2 wait cycles, ready for one cycle
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready <= 1'b0;
            wait_cnt  <= int'($urandom % 3);
        end else if (mem_req) begin
            if (wait_cnt == 0) begin
                mem_ready <= 1'b1;
                beats     <= beats + 1;
                if (mem_we) mem[mem_addr] = mem_wdata;
                else mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : dflt(mem_addr);
            end else wait_cnt <= wait_cnt - 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1; checks = checks + 1;
            $display("FAIL watchdog expired act=%0d exp<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_fmt(input logic [7:0] v, input logic [31:0] sp,
                                            input logic [15:0] sr);
        return {2'b01, sp[1:0], 2'b00, v, 2'b00, sr};
    endfunction

    function automatic logic [15:0] exp_sr(input logic [15:0] sr, input logic hw,
                                           input logic [2:0] lv);
        logic [15:0] s = sr | 16'h2000;
        if (hw) s = (s & ~16'h1700) | {5'b0, lv, 8'h00};
        return s;
    endfunction

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic round_trip(input logic [7:0] v, input logic hw, input logic [2:0] lv,
                              input logic [31:0] pc, input logic [15:0] sr,
                              input logic [31:0] sp, input logic [31:0] vbr);
        logic [31:0] base = {sp[31:2], 2'b00};
        logic [31:0] rexp = (v >= 8'd32 && v <= 8'd47) ? pc + 32'd2 : pc;
        int b0;
        @(negedge clk);
        exc_vec = v; exc_hw = hw; exc_level = lv; cur_pc = pc; cur_sr = sr;
        cur_sp = sp; cur_vbr = vbr; exc_valid = 1'b1; b0 = beats;
        @(negedge clk);
        exc_valid = 1'b0;
        chk("R8 busy after accept", {31'b0, busy}, 32'd1);
        wait_done();
        chk("R5 new pc from vector", new_pc, dflt(vbr + {22'b0, v, 2'b00}));
        chk("R4 new sr", {16'b0, new_sr}, {16'b0, exp_sr(sr, hw, lv)});
        chk("R2 new sp", new_sp, base - 32'd8);
        chk("R3 saved return", mem.exists(base - 32'd4) ? mem[base - 32'd4] : 32'hDEAD_DEAD, rexp);
        chk("R1 format word", mem.exists(base - 32'd8) ? mem[base - 32'd8] : 32'hDEAD_DEAD,
            exp_fmt(v, sp, sr));
        chk("R8 three accesses", beats - b0, 32'd3);
        @(negedge clk);
        chk("R9 done one cycle", {31'b0, done}, 32'd0);
        // return from the committed stack pointer
        cur_sp = new_sp; cur_sr = new_sr; ret_valid = 1'b1; b0 = beats;
        @(negedge clk);
        ret_valid = 1'b0;
        wait_done();
        chk("R6 restored pc", new_pc, rexp);
        chk("R6 restored sr", {16'b0, new_sr}, {16'b0, sr});
        chk("R6 restored sp", new_sp, sp);
        chk("R8 two accesses", beats - b0, 32'd2);
    endtask

    task automatic ignored_hw(input logic [15:0] sr, input logic [2:0] lv);
        logic [31:0] pc0 = new_pc;
        int bad = 0;
        @(negedge clk);
        exc_vec = 8'd25; exc_hw = 1'b1; exc_level = lv; cur_sr = sr; exc_valid = 1'b1;
        @(negedge clk);
        exc_valid = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (busy || mem_req || done) bad++;
            @(negedge clk);
        end
        chk("R7 low level ignored", bad, 32'd0);
        chk("R7 pc unchanged", new_pc, pc0);
    endtask

    initial begin
        void'($urandom(32'd715));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset busy", {31'b0, busy}, 32'd0);
        chk("R10 reset req", {31'b0, mem_req}, 32'd0);
        chk("R10 reset done", {31'b0, done}, 32'd0);
        chk("R10 reset outputs", new_pc | new_sp | {16'b0, new_sr}, 32'd0);

        // directed corners: trap edges, sp low bits, master bit
        round_trip(8'd32, 1'b0, 3'd0, 32'h0000_1000, 16'h0015, 32'h0000_8000, 32'h0000_0400);
        round_trip(8'd47, 1'b0, 3'd0, 32'h0000_2002, 16'h0700, 32'h0000_8001, 32'h0000_0000);
        round_trip(8'd31, 1'b0, 3'd0, 32'h0000_3000, 16'h001F, 32'h0000_8002, 32'h0001_0000);
        round_trip(8'd48, 1'b0, 3'd0, 32'h0000_4004, 16'h2000, 32'h0000_8003, 32'h0001_0000);
        round_trip(8'd26, 1'b1, 3'd2, 32'h1234_5678, 16'h1104, 32'h0000_9003, 32'h0000_0800);
        round_trip(8'd31, 1'b1, 3'd7, 32'h8000_0000, 16'h3600, 32'h0000_0002, 32'hFFFF_F000);
        ignored_hw(16'h0500, 3'd5);
        ignored_hw(16'h0500, 3'd3);
        ignored_hw(16'h0700, 3'd7);

        for (int n = 0; n < 40; n++) begin
            logic hw = $urandom % 2;
            logic [2:0] lv = 3'($urandom % 7) + 3'd1;
            logic [15:0] sr = 16'($urandom);
            if (hw) sr[10:8] = 3'($urandom % int'(lv));
            round_trip(8'($urandom), hw, lv, {$urandom, 1'b0} , sr,
                       32'h1000_0000 | 32'($urandom % 32'h00FF_FFFF),
                       {$urandom % 32'h0001_0000, 10'b0});
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule